// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 1024 four-bit words. The RAM shares one data bus for both directions and has active-low chip-enable and write-enable pins. The host issues one access at a time over a request/ready handshake. The controller owns every memory pin: the address, both strobes, and a data driver with its own output-enable. The board's tristate pad combines the driver, the enable and the returned data.

All analog timing rules become whole-cycle counts set by parameters: read access time, minimum write strobe width, data setup before the end of a write, and how long to wait for the memory to release the bus. A single parameter picks how a write is strobed. In the first form, chip-enable and write-enable fall together and the drivers turn on only after the release wait. In the second form, write-enable falls while the chip is still deselected, which lets the drivers turn on at once, and a chip-enable pulse then makes the write. Between accesses the memory sits in standby with the drivers off.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset, and whenever `ready` is 1, the pins are in standby: `memCeN`=1, `memWeN`=1, `memDoe`=0. After reset `ready`=1 and `rdataValid`=0.
- R2: An access is accepted at a rising edge where `req` and `ready` are both 1. `rw`=1 means write and `rw`=0 means read. `ready` then stays 0 until the access ends. A write keeps it low for LEAD+DRIVE cycles and a read for ACCESS_CYC+TURN_CYC cycles. LEAD and DRIVE are defined in R6 and R7.
- R3: In the first cycle of a read, `memCeN`=0, `memWeN`=1, `memDoe`=0, and `memAddr` already holds the accepted address. The address does not change while chip-enable stays low.
- R4: The read word is sampled from `memDin` at the edge ending the ACCESS_CYC-th cycle of chip-enable low. `rdataValid` is 1 for exactly one cycle after that edge, with the word on `rdata`.
- R5: `memDoe` is never 1 while `memCeN`=0 and `memWeN`=1. After a read, chip-enable stays high for TURN_CYC cycles (TURN_CYC >= 1) before the next access can be accepted.
- R6: With CE_MODE=0, both strobes fall in the first write cycle with `memDoe`=0. `memDoe` rises after TURN_CYC cycles of write-enable low. LEAD=TURN_CYC and DRIVE=max(STROBE_CYC-TURN_CYC, SETUP_CYC, 1).
- R7: With CE_MODE=1, the first write cycle has `memWeN`=0, `memCeN`=1 and `memDoe`=1. Chip-enable is low for the remaining cycles. LEAD=1 and DRIVE=max(STROBE_CYC, SETUP_CYC-1, 1).
- R8: Every write holds both strobes low for at least STROBE_CYC cycles. The data is driven for at least SETUP_CYC cycles before the strobes are released.
- R9: A write ends with both strobes rising at the same edge and `memDoe` falling at that edge. `memAddr` is unchanged from the first write cycle through that edge.
- R10: Every word written at every address reads back unchanged, in both strobe modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| rw | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | Idle, accepts a request |
| rdata | output | DATA_W | Read word |
| rdataValid | output | 1 | One-cycle strobe for `rdata` |
| memAddr | output | ADDR_W | Memory address pins |
| memCeN | output | 1 | Memory chip-enable, active low |
| memWeN | output | 1 | Memory write-enable, active low |
| memDoe | output | 1 | Enables the controller's data drivers |
| memDout | output | DATA_W | Data driven toward the memory |
| memDin | input | DATA_W | Data seen on the memory bus |

## Verification
The bench samples at falling edges. The k-th falling edge after the accepting rising edge shows the state reached after k register updates. The pin pattern of the first access cycle is therefore checked at k=1. `rdataValid` is due at k=ACCESS_CYC+1, and `ready` returns at k=LEAD+DRIVE+1 for writes and at k=ACCESS_CYC+TURN_CYC+1 for reads. For every access the bench counts the cycles with both strobes low and the cycles with drivers on, and compares them with the counts from R6 to R8. One controller per strobe mode runs in lockstep, and each mode drives its own behavioural memory that records bus contention.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef struct packed {
    logic ceN;
    logic weN;
    logic doe;
  } pins_t;

  typedef struct packed {
    logic  loadReq;
    logic  capture;
    pins_t pins;
  } ctl_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WLEAD,
    ST_WDRIVE
  } ctl_state_t;

  localparam pins_t PINS_STANDBY = '{ceN: 1'b1, weN: 1'b1, doe: 1'b0};

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_ctrl_pkg::*;
#(
  parameter int ACCESS_CYC = 1,
  parameter int STROBE_CYC = 1,
  parameter int SETUP_CYC  = 1,
  parameter int TURN_CYC   = 1,
  parameter bit CE_MODE    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        rw,
  output logic        ready,
  output ctl_strobe_t stb
);

  localparam int WeDriveA = (STROBE_CYC > TURN_CYC) ? STROBE_CYC - TURN_CYC : 1;
  localparam int WeDrive  = (SETUP_CYC > WeDriveA) ? SETUP_CYC : WeDriveA;
  localparam int CeDriveA = (STROBE_CYC > 1) ? STROBE_CYC : 1;
  localparam int CeDrive  = (SETUP_CYC - 1 > CeDriveA) ? SETUP_CYC - 1 : CeDriveA;
  localparam int LeadCyc  = CE_MODE ? 1 : TURN_CYC;
  localparam int DriveCyc = CE_MODE ? CeDrive : WeDrive;
  localparam int MaxA     = (ACCESS_CYC > TURN_CYC) ? ACCESS_CYC : TURN_CYC;
  localparam int MaxB     = (LeadCyc > DriveCyc) ? LeadCyc : DriveCyc;
  localparam int MaxCyc   = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int CntW     = $clog2(MaxCyc + 1);

  pins_t leadPins;

  generate
    if (CE_MODE) begin : g_ce_strobe
      assign leadPins = '{ceN: 1'b1, weN: 1'b0, doe: 1'b1};
    end else begin : g_we_strobe
      assign leadPins = '{ceN: 1'b0, weN: 1'b0, doe: 1'b0};
    end
  endgenerate

  ctl_state_t      state, stateNext;
  logic [CntW-1:0] cnt, cntNext;
  pins_t           pinsQ, pinsNext;
  logic            loadReq, capture;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    loadReq   = 1'b0;
    capture   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req) begin
          loadReq = 1'b1;
          if (rw) begin
            stateNext = ST_WLEAD;
            cntNext   = CntW'(LeadCyc - 1);
          end else begin
            stateNext = ST_READ;
            cntNext   = CntW'(ACCESS_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          capture   = 1'b1;
          stateNext = ST_TURN;
          cntNext   = CntW'(TURN_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WLEAD: begin
        if (cnt == '0) begin
          stateNext = ST_WDRIVE;
          cntNext   = CntW'(DriveCyc - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WDRIVE: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // Pin levels follow the state being entered, from registers only.
  always_comb begin
    case (stateNext)
      ST_READ:   pinsNext = '{ceN: 1'b0, weN: 1'b1, doe: 1'b0};
      ST_WLEAD:  pinsNext = leadPins;
      ST_WDRIVE: pinsNext = '{ceN: 1'b0, weN: 1'b0, doe: 1'b1};
      default:   pinsNext = PINS_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pinsQ <= PINS_STANDBY;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      pinsQ <= pinsNext;
    end
  end

  assign ready       = (state == ST_IDLE);
  assign stb.loadReq = loadReq;
  assign stb.capture = capture;
  assign stb.pins    = pinsQ;

endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_strobe_t       stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic [DATA_W-1:0] rdata,
  output logic              rdataValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              validQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ  <= '0;
      dataQ  <= '0;
      rdataQ <= '0;
      validQ <= 1'b0;
    end else begin
      if (stb.loadReq) begin
        addrQ <= addr;
        dataQ <= wdata;
      end
      if (stb.capture) rdataQ <= memDin;
      validQ <= stb.capture;
    end
  end

  assign memAddr    = addrQ;
  assign memDout    = dataQ;
  assign rdata      = rdataQ;
  assign rdataValid = validQ;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 4,
  parameter int ACCESS_CYC = 1,
  parameter int STROBE_CYC = 1,
  parameter int SETUP_CYC  = 1,
  parameter int TURN_CYC   = 1,
  parameter bit CE_MODE    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rdataValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memDoe,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin
);

  ctl_strobe_t stb;

  asram_ctrl_fsm #(
    .ACCESS_CYC(ACCESS_CYC),
    .STROBE_CYC(STROBE_CYC),
    .SETUP_CYC (SETUP_CYC),
    .TURN_CYC  (TURN_CYC),
    .CE_MODE   (CE_MODE)
  ) fsm_i (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .rw   (rw),
    .ready(ready),
    .stb  (stb)
  );

  asram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .addr      (addr),
    .wdata     (wdata),
    .memDin    (memDin),
    .memAddr   (memAddr),
    .memDout   (memDout),
    .rdata     (rdata),
    .rdataValid(rdataValid)
  );

  assign memCeN = stb.pins.ceN;
  assign memWeN = stb.pins.weN;
  assign memDoe = stb.pins.doe;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W     = 10,
  parameter int STROBE_CYC = 1,
  parameter int SETUP_CYC  = 1,
  parameter int TURN_CYC   = 1,
  parameter bit CE_MODE    = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rdataValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memDoe
);

  logic [7:0] strobeRun, doeRun, weLowRun;
  logic       bothLow, strobeEnd, active;

  assign bothLow   = !memCeN && !memWeN;
  assign strobeEnd = !bothLow && (strobeRun != 8'd0);
  assign active    = !memCeN || !memWeN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobeRun <= 8'd0;
      doeRun    <= 8'd0;
      weLowRun  <= 8'd0;
    end else begin
      strobeRun <= bothLow ? ((strobeRun == 8'hff) ? strobeRun : strobeRun + 8'd1) : 8'd0;
      doeRun    <= memDoe  ? ((doeRun == 8'hff) ? doeRun : doeRun + 8'd1) : 8'd0;
      weLowRun  <= !memWeN ? ((weLowRun == 8'hff) ? weLowRun : weLowRun + 8'd1) : 8'd0;
    end
  end

  a_r1_ready_standby: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (memCeN && memWeN && !memDoe));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    memDoe |-> (memCeN || !memWeN));

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdataValid |=> !rdataValid);

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(memAddr));

  a_r9_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWeN) |-> ($rose(memCeN) && !memDoe));

  a_r8_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    strobeEnd |-> (int'(strobeRun) >= STROBE_CYC));

  a_r8_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
    strobeEnd |-> (int'(doeRun) >= SETUP_CYC));

  generate
    if (CE_MODE) begin : g_ce_props
      a_r7_we_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(memWeN) |-> (memCeN && memDoe));
    end else begin : g_we_props
      a_r6_turn_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(memDoe) |-> (int'(weLowRun) >= TURN_CYC));
      a_r6_joint_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(memWeN) |-> ($fell(memCeN) && !memDoe));
    end
  endgenerate

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .STROBE_CYC(STROBE_CYC),
  .SETUP_CYC (SETUP_CYC),
  .TURN_CYC  (TURN_CYC),
  .CE_MODE   (CE_MODE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .rdataValid(rdataValid),
  .memAddr   (memAddr),
  .memCeN    (memCeN),
  .memWeN    (memWeN),
  .memDoe    (memDoe)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_model #(
  parameter int AW = 10,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          ceN,
  input  logic          weN,
  input  logic          doe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dout,
  output logic [DW-1:0] din,
  output logic          clash
);
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] pendD;
  logic [AW-1:0] pendA;
  logic          pend = 1'b0;

  initial clash = 1'b0;

  assign din = (!ceN && weN) ? mem[addr] : '0;

  always @(negedge clk) begin
    if (doe && !ceN && weN) clash <= 1'b1;
    if (!ceN && !weN) begin
      if (doe) begin
        pendD <= dout;
        pendA <= addr;
        pend  <= 1'b1;
      end
    end else if (pend) begin
      mem[pendA] <= pendD;
      pend       <= 1'b0;
    end
  end
endmodule

module asram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam int ACC = 1;
  localparam int STRB = 1;
  localparam int SETUP = 1;
  localparam int TURN = 1;

  localparam int LEAD_W  = TURN;
  localparam int DRV_W0  = (STRB - TURN > 1) ? STRB - TURN : 1;
  localparam int DRIVE_W = (SETUP > DRV_W0) ? SETUP : DRV_W0;
  localparam int LEAD_C  = 1;
  localparam int DRV_C0  = (STRB > 1) ? STRB : 1;
  localparam int DRIVE_C = (SETUP - 1 > DRV_C0) ? SETUP - 1 : DRV_C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;

  logic readyW, vldW, ceW, weW, doeW, clashW;
  logic [DW-1:0] rdW, doutW, dinW;
  logic [AW-1:0] maW;
  logic readyC, vldC, ceC, weC, doeC, clashC;
  logic [DW-1:0] rdC, doutC, dinC;
  logic [AW-1:0] maC;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC), .STROBE_CYC(STRB),
               .SETUP_CYC(SETUP), .TURN_CYC(TURN), .CE_MODE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .addr(addr), .wdata(wdata),
    .ready(readyW), .rdata(rdW), .rdataValid(vldW), .memAddr(maW),
    .memCeN(ceW), .memWeN(weW), .memDoe(doeW), .memDout(doutW), .memDin(dinW));

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC), .STROBE_CYC(STRB),
               .SETUP_CYC(SETUP), .TURN_CYC(TURN), .CE_MODE(1'b1)) dut_ce_i (
    .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .addr(addr), .wdata(wdata),
    .ready(readyC), .rdata(rdC), .rdataValid(vldC), .memAddr(maC),
    .memCeN(ceC), .memWeN(weC), .memDoe(doeC), .memDout(doutC), .memDin(dinC));

  asram_model #(.AW(AW), .DW(DW)) memW_i (.clk(clk), .ceN(ceW), .weN(weW), .doe(doeW),
    .addr(maW), .dout(doutW), .din(dinW), .clash(clashW));
  asram_model #(.AW(AW), .DW(DW)) memC_i (.clk(clk), .ceN(ceC), .weN(weC), .doe(doeC),
    .addr(maC), .dout(doutC), .din(dinC), .clash(clashC));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // per-access observations
  int opLat, lowW, lowC, drvW, drvC, vldCntW, vldCntC, vldAtW, vldAtC;
  logic [DW-1:0] gotW, gotC;
  logic [2:0] firstW, firstC;   // {ceN, weN, doe} in the first access cycle
  logic [AW-1:0] firstAddrW, firstAddrC;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int a, input int salt);
    return DW'((a * 5) + (a >> 4) + salt);
  endfunction

  task automatic do_op(input logic isWr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!readyW) @(negedge clk);
    req = 1'b1; rw = isWr; addr = a; wdata = d;
    opLat = 0; lowW = 0; lowC = 0; drvW = 0; drvC = 0;
    vldCntW = 0; vldCntC = 0; vldAtW = 0; vldAtC = 0;
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      req = 1'b0;
      if (k == 1) begin
        firstW = {ceW, weW, doeW}; firstC = {ceC, weC, doeC};
        firstAddrW = maW; firstAddrC = maC;
      end
      if (!ceW && !weW) lowW++;
      if (!ceC && !weC) lowC++;
      if (doeW) drvW++;
      if (doeC) drvC++;
      if (vldW) begin vldCntW++; vldAtW = k; gotW = rdW; end
      if (vldC) begin vldCntC++; vldAtC = k; gotC = rdC; end
      if (readyW) begin opLat = k; break; end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ceW && weW && !doeW && readyW && !vldW, "R1", "WE-mode pins in reset",
          {ceW, weW, doeW, readyW, vldW}, 5'b11010);
    check(ceC && weC && !doeC && readyC && !vldC, "R1", "CE-mode pins in reset",
          {ceC, weC, doeC, readyC, vldC}, 5'b11010);
    rst_n = 1'b1;
    @(negedge clk);
    check(readyW && ceW && !doeW, "R1", "idle after reset", {readyW, ceW, doeW}, 3'b110);

    // Directed write
    do_op(1'b1, 10'd5, 4'hA);
    check(firstW == 3'b000, "R6", "WE-mode first write cycle {ce,we,oe}", firstW, 3'b000);
    check(firstC == 3'b101, "R7", "CE-mode first write cycle {ce,we,oe}", firstC, 3'b101);
    check(firstAddrW == 10'd5, "R9", "address in first write cycle", firstAddrW, 5);
    check(opLat == LEAD_W + DRIVE_W + 1, "R2", "write busy length", opLat, LEAD_W + DRIVE_W + 1);
    check(ceW && weW && !doeW && ceC && weC && !doeC, "R9", "standby after write",
          {ceW, weW, doeW, ceC, weC, doeC}, 6'b110110);

    // Directed read
    do_op(1'b0, 10'd5, 4'h0);
    check(firstW == 3'b010 && firstAddrW == 10'd5, "R3", "first read cycle {ce,we,oe}",
          firstW, 3'b010);
    check(firstC == 3'b010 && firstAddrC == 10'd5, "R3", "CE-mode first read cycle", firstC, 3'b010);
    check(vldAtW == ACC + 1, "R4", "valid cycle", vldAtW, ACC + 1);
    check(vldCntW == 1 && vldCntC == 1, "R4", "valid pulse count", vldCntW + vldCntC, 2);
    check(gotW == 4'hA && gotC == 4'hA, "R4", "read word", gotW, 4'hA);
    check(opLat == ACC + TURN + 1, "R5", "read busy incl. turnaround", opLat, ACC + TURN + 1);

    // Sweep: write every address in both modes
    for (int a = 0; a < 2**AW; a++) begin
      do_op(1'b1, AW'(a), pattern(a, 3));
      check(opLat == LEAD_W + DRIVE_W + 1, "R2", "write latency", opLat, LEAD_W + DRIVE_W + 1);
      check(lowW >= STRB && lowW == LEAD_W + DRIVE_W, "R8", "WE-mode strobe cycles",
            lowW, LEAD_W + DRIVE_W);
      check(lowC >= STRB && lowC == DRIVE_C, "R8", "CE-mode strobe cycles", lowC, DRIVE_C);
      check(drvW >= SETUP && drvW == DRIVE_W, "R6", "WE-mode drive cycles", drvW, DRIVE_W);
      check(drvC >= SETUP && drvC == LEAD_C + DRIVE_C, "R7", "CE-mode drive cycles",
            drvC, LEAD_C + DRIVE_C);
    end
    // Sweep: read every address back
    for (int a = 0; a < 2**AW; a++) begin
      do_op(1'b0, AW'(a), 4'h0);
      check(vldCntW == 1 && gotW == pattern(a, 3), "R10", "WE-mode read back",
            gotW, pattern(a, 3));
      check(vldCntC == 1 && gotC == pattern(a, 3), "R10", "CE-mode read back",
            gotC, pattern(a, 3));
      check(vldAtW == ACC + 1 && opLat == ACC + TURN + 1, "R4", "read timing",
            vldAtW, ACC + 1);
    end
    check(!clashW && !clashC, "R5", "bus contention seen by memory", {clashW, clashC}, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule